// File: doc/BRIEF.md
# Branch Target and Register Update Resolver

This block resolves a single branch instruction of a 64-bit RISC architecture. Its bits and fields are numbered big-endian: bit 0 is the most significant bit. With a valid strobe it takes the following inputs:

- the instruction word and the address of that instruction;
- the condition register;
- the link, counter and target registers;
- a flag that selects 64-bit or 32-bit addressing.

One clock later it returns the results of that instruction:

- the address to fetch next;
- the write enable and write data for the link register;
- the write enable and write data for the counter register;
- a flag that marks the instruction as illegal.

The surrounding pipeline owns the architectural registers. It uses these registered results to redirect fetch and to commit the register updates. The block covers three groups of branch:

- unconditional branches, relative or absolute;
- conditional branches with a 14-bit displacement;
- conditional branches through the link, counter or target register.

Every form has a link variant that also saves the return address. The block evaluates a five-bit option field in each conditional branch. That field controls three things: a condition-register test, an optional counter decrement, and the zero test that follows the decrement. The zero test looks at 64 bits or at 32 bits, depending on the addressing mode.

Top module: `bru_resolve`

## Requirements
- R1: `out_valid` is high in the cycle after `in_valid` was sampled high and low otherwise. The enables and `illegal` are low unless `out_valid` is high. Reset clears every output to zero.
- R2: The primary opcode is `insn[31:26]`: 18 is the unconditional form and 16 is the conditional displacement form. Opcode 19 with extended opcode `insn[10:1]` equal to 16, 528 or 560 selects the branch through the link, counter or target register. Every other combination is illegal.
- R3: The option field is `insn[25:21]`, and option bit 0 is `insn[25]`. `insn[20:16]` selects condition bit `cr[31-sel]`. The condition test passes when option bit 0 is set or when the selected bit equals option bit 1 (`insn[24]`).
- R4: When option bit 2 (`insn[23]`) is clear in any form other than the counter-register form, `ctr_we` is raised and `ctr_wdata` is `ctr_in-1`. The counter test then passes when the decremented value is nonzero and option bit 3 (`insn[22]`) is clear, or when it is zero and option bit 3 is set. When option bit 2 is set, the counter test passes.
- R5: In 64-bit mode the zero test examines all 64 bits of the decremented counter. In 32-bit mode it examines only the low 32 bits.
- R6: An unconditional branch is always taken. A conditional branch is taken when both tests pass; the counter-register form uses only the condition test. A branch that is not taken yields `cia+4`.
- R7: A relative target is `cia` plus the sign-extended displacement shifted left by 2. The displacement is `insn[25:2]` for opcode 18 and `insn[15:2]` for opcode 16. When `insn[1]` is set, the target is the shifted displacement alone.
- R8: An indirect target is the link, counter or target register with its two low bits cleared. The counter-register form never writes the counter.
- R9: The counter-register form is illegal when option bit 2 is clear. Every option value is legal for the other conditional forms.
- R10: An illegal instruction raises `illegal`, clears both write enables and returns `nia = cia`.
- R11: When `insn[0]` is set, `lr_we` is raised and `lr_wdata` is `cia+4`. A branch through the link register reads the old link value as its target.
- R12: In 32-bit mode the upper 32 bits of `nia` and `lr_wdata` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| cia | input | 64 | Address of the instruction |
| cr | input | 32 | Condition register |
| lr_in | input | 64 | Current link register |
| ctr_in | input | 64 | Current counter register |
| tar_in | input | 64 | Current target register |
| mode64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| out_valid | output | 1 | Result valid pulse |
| nia | output | 64 | Next instruction address |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 64 | Link register write data |
| ctr_we | output | 1 | Counter write enable |
| ctr_wdata | output | 64 | Counter write data |
| illegal | output | 1 | Illegal instruction flag |

## Verification
The assertions check the following on every cycle:

- the one-cycle valid timing;
- that an illegal result never writes a register;
- that a counter write is always the previous counter minus one;
- that the link data is the return address;
- that 32-bit mode leaves the upper address half zero;
- that the counter-register form never decrements.

Only the bench's scenarios can show which way each branch resolves. That covers the condition-bit selection, the counter zero test in each mode and the target arithmetic. The bench sweeps every option encoding across every conditional form, both modes and counter values chosen so that the 32-bit and 64-bit zero tests disagree.

// File: rtl/bru_pkg.sv
package bru_pkg;

  parameter int unsigned AW  = 64;
  parameter int unsigned IW  = 32;
  parameter int unsigned CRW = 32;
  parameter int unsigned OPW = 5;
  localparam int unsigned HW   = AW / 2;
  localparam int unsigned SELW = $clog2(CRW);

  typedef enum logic [2:0] {
    FORM_UNCOND,
    FORM_COND,
    FORM_VIA_LR,
    FORM_VIA_CTR,
    FORM_VIA_TAR,
    FORM_BAD
  } form_e;

  // Option encodings accepted; counter-register form excludes decrementing ones
  function automatic logic opt_legal(input logic [OPW-1:0] opt, input logic via_ctr);
    logic ok;
    ok = (opt ==? 5'b001??) | (opt ==? 5'b011??) | (opt ==? 5'b1?1??);
    if (!via_ctr)
      ok = ok | (opt ==? 5'b0000?) | (opt ==? 5'b0001?) | (opt ==? 5'b0100?)
              | (opt ==? 5'b0101?) | (opt ==? 5'b1?00?) | (opt ==? 5'b1?01?);
    return ok;
  endfunction

  function automatic logic cond_pass(input logic [OPW-1:0] opt, input logic crbit);
    return opt[OPW-1] | (crbit == opt[OPW-2]);
  endfunction

  function automatic logic count_pass(input logic [OPW-1:0] opt, input logic nonzero);
    return opt[OPW-3] | (nonzero ^ opt[OPW-4]);
  endfunction

  function automatic logic [AW-1:0] fit_addr(input logic [AW-1:0] a, input logic wide);
    return wide ? a : {{HW{1'b0}}, a[HW-1:0]};
  endfunction

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [IW-1:0]   insn,
  output form_e           form,
  output logic [OPW-1:0]  opt,
  output logic [SELW-1:0] crsel,
  output logic            absolute,
  output logic            link,
  output logic [AW-1:0]   disp,
  output logic            bad_op
);
  localparam int unsigned PRIW  = 6;
  localparam int unsigned XOW   = 10;
  localparam int unsigned LONGW = 24;
  localparam int unsigned SHRTW = 14;

  localparam logic [PRIW-1:0] PRI_UNCOND = 6'd18;
  localparam logic [PRIW-1:0] PRI_COND   = 6'd16;
  localparam logic [PRIW-1:0] PRI_IND    = 6'd19;
  localparam logic [XOW-1:0]  XO_LR      = 10'd16;
  localparam logic [XOW-1:0]  XO_CTR     = 10'd528;
  localparam logic [XOW-1:0]  XO_TAR     = 10'd560;

  logic [PRIW-1:0]  pri;
  logic [XOW-1:0]   xo;
  logic [LONGW-1:0] long_d;
  logic [SHRTW-1:0] short_d;

  assign pri      = insn[IW-1 -: PRIW];
  assign opt      = insn[IW-PRIW-1 -: OPW];
  assign crsel    = insn[IW-PRIW-OPW-1 -: SELW];
  assign xo       = insn[XOW:1];
  assign long_d   = insn[LONGW+1:2];
  assign short_d  = insn[SHRTW+1:2];
  assign absolute = insn[1];
  assign link     = insn[0];

  always_comb begin
    form = FORM_BAD;
    disp = '0;
    case (pri)
      PRI_UNCOND: begin
        form = FORM_UNCOND;
        disp = {{(AW-LONGW-2){long_d[LONGW-1]}}, long_d, 2'b00};
      end
      PRI_COND: begin
        form = FORM_COND;
        disp = {{(AW-SHRTW-2){short_d[SHRTW-1]}}, short_d, 2'b00};
      end
      PRI_IND: begin
        case (xo)
          XO_LR:   form = FORM_VIA_LR;
          XO_CTR:  form = FORM_VIA_CTR;
          XO_TAR:  form = FORM_VIA_TAR;
          default: form = FORM_BAD;
        endcase
      end
      default: form = FORM_BAD;
    endcase
  end

  assign bad_op = (form == FORM_BAD);
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  form_e           form,
  input  logic [OPW-1:0]  opt,
  input  logic [SELW-1:0] crsel,
  input  logic [CRW-1:0]  cr,
  input  logic [AW-1:0]   ctr,
  input  logic            wide,
  output logic            taken,
  output logic            dec_en,
  output logic [AW-1:0]   ctr_dec,
  output logic            opt_bad
);
  logic [CRW-1:0] cr_rev;
  logic           crbit;
  logic           nonzero;
  logic           c_ok;
  logic           n_ok;
  logic           is_cond;

  // Reverse so index 0 is the most significant condition bit
  for (genvar i = 0; i < CRW; i++) begin : g_rev
    assign cr_rev[i] = cr[CRW-1-i];
  end

  assign crbit   = cr_rev[crsel];
  assign ctr_dec = ctr - 1'b1;
  assign nonzero = wide ? (|ctr_dec) : (|ctr_dec[HW-1:0]);
  assign c_ok    = cond_pass(opt, crbit);
  assign n_ok    = count_pass(opt, nonzero);
  assign is_cond = (form == FORM_COND) || (form == FORM_VIA_LR) ||
                   (form == FORM_VIA_CTR) || (form == FORM_VIA_TAR);
  assign dec_en  = is_cond && (form != FORM_VIA_CTR) && !opt[OPW-3];
  assign opt_bad = is_cond && !opt_legal(opt, form == FORM_VIA_CTR);

  always_comb begin
    case (form)
      FORM_UNCOND:  taken = 1'b1;
      FORM_VIA_CTR: taken = c_ok;
      FORM_BAD:     taken = 1'b0;
      default:      taken = c_ok & n_ok;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
(
  input  form_e         form,
  input  logic          taken,
  input  logic          absolute,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] cia,
  input  logic [AW-1:0] lr,
  input  logic [AW-1:0] ctr,
  input  logic [AW-1:0] tar,
  input  logic          wide,
  output logic [AW-1:0] nia_next,
  output logic [AW-1:0] link_next
);
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] jump_addr;

  assign seq_addr = cia + AW'(4);

  always_comb begin
    case (form)
      FORM_UNCOND, FORM_COND: jump_addr = absolute ? disp : (cia + disp);
      FORM_VIA_LR:            jump_addr = word_align(lr);
      FORM_VIA_CTR:           jump_addr = word_align(ctr);
      FORM_VIA_TAR:           jump_addr = word_align(tar);
      default:                jump_addr = seq_addr;
    endcase
  end

  assign nia_next  = fit_addr(taken ? jump_addr : seq_addr, wide);
  assign link_next = fit_addr(seq_addr, wide);
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic [63:0]   cia,
  input  logic [31:0]   cr,
  input  logic [63:0]   lr_in,
  input  logic [63:0]   ctr_in,
  input  logic [63:0]   tar_in,
  input  logic          mode64,
  output logic          out_valid,
  output logic [63:0]   nia,
  output logic          lr_we,
  output logic [63:0]   lr_wdata,
  output logic          ctr_we,
  output logic [63:0]   ctr_wdata,
  output logic          illegal
);
  form_e           form;
  logic [OPW-1:0]  opt;
  logic [SELW-1:0] crsel;
  logic            absolute;
  logic            link;
  logic [AW-1:0]   disp;
  logic            bad_op;
  logic            taken;
  logic            dec_en;
  logic [AW-1:0]   ctr_dec;
  logic            opt_bad;
  logic [AW-1:0]   nia_next;
  logic [AW-1:0]   link_next;
  logic            ill_now;

  bru_decode u_decode (
    .insn(insn), .form(form), .opt(opt), .crsel(crsel),
    .absolute(absolute), .link(link), .disp(disp), .bad_op(bad_op)
  );

  bru_cond u_cond (
    .form(form), .opt(opt), .crsel(crsel), .cr(cr), .ctr(ctr_in),
    .wide(mode64), .taken(taken), .dec_en(dec_en), .ctr_dec(ctr_dec),
    .opt_bad(opt_bad)
  );

  bru_target u_target (
    .form(form), .taken(taken), .absolute(absolute), .disp(disp),
    .cia(cia), .lr(lr_in), .ctr(ctr_in), .tar(tar_in), .wide(mode64),
    .nia_next(nia_next), .link_next(link_next)
  );

  assign ill_now = bad_op | opt_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      nia       <= '0;
      lr_we     <= 1'b0;
      lr_wdata  <= '0;
      ctr_we    <= 1'b0;
      ctr_wdata <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      lr_we     <= in_valid & ~ill_now & link;
      ctr_we    <= in_valid & ~ill_now & dec_en;
      illegal   <= in_valid & ill_now;
      if (in_valid) begin
        nia       <= ill_now ? cia : nia_next;
        lr_wdata  <= link_next;
        ctr_wdata <= ctr_dec;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !lr_we && !ctr_we && !illegal)); // R1
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (!lr_we && !ctr_we)); // R10
  AST_CTR_MINUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_we |-> (ctr_wdata + 64'd1 == $past(ctr_in))); // R4
  AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (lr_wdata[31:0] == $past(cia[31:0]) + 32'd4)); // R11
  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal && !$past(mode64)) |-> (nia[63:32] == 32'd0 && lr_wdata[63:32] == 32'd0)); // R12
  AST_CTRFORM_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == FORM_VIA_CTR) |=> !ctr_we); // R8
endmodule

// File: tb/bru_resolve_tb_top.sv
`timescale 1ns/100ps
module bru_resolve_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] cia = '0;
  logic [31:0] cr = '0;
  logic [63:0] lr_in = '0;
  logic [63:0] ctr_in = '0;
  logic [63:0] tar_in = '0;
  logic        mode64 = 1'b0;
  logic        out_valid, lr_we, ctr_we, illegal;
  logic [63:0] nia, lr_wdata, ctr_wdata;

  int total = 0;
  int bad = 0;

  logic [63:0] e_nia, e_lrd, e_ctrd;
  logic        e_lrwe, e_ctrwe, e_ill;

  always #2.5 clk = ~clk;

  bru_resolve dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .cia(cia),
    .cr(cr), .lr_in(lr_in), .ctr_in(ctr_in), .tar_in(tar_in), .mode64(mode64),
    .out_valid(out_valid), .nia(nia), .lr_we(lr_we), .lr_wdata(lr_wdata),
    .ctr_we(ctr_we), .ctr_wdata(ctr_wdata), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_b(input logic [23:0] li, input logic aa, input logic lk);
    return {6'd18, li, aa, lk};
  endfunction
  function automatic logic [31:0] mk_bc(input logic [4:0] bo, input logic [4:0] bi,
                                        input logic [13:0] bd, input logic aa, input logic lk);
    return {6'd16, bo, bi, bd, aa, lk};
  endfunction
  function automatic logic [31:0] mk_ind(input logic [4:0] bo, input logic [4:0] bi,
                                         input logic [9:0] xo, input logic lk);
    return {6'd19, bo, bi, 5'd0, xo, lk};
  endfunction

  // Reference model written from the requirements
  task automatic predict();
    int kind;
    logic [4:0] bo;
    int sel;
    logic crbit, cpass, npass, zero, legal, tk;
    logic [63:0] dec, off, tgt, seq;
    bo  = insn[25:21];
    sel = int'(insn[20:16]);
    if (insn[31:26] == 6'd18) kind = 0;                                  // R2
    else if (insn[31:26] == 6'd16) kind = 1;
    else if (insn[31:26] == 6'd19 && insn[10:1] == 10'd16) kind = 2;
    else if (insn[31:26] == 6'd19 && insn[10:1] == 10'd528) kind = 3;
    else if (insn[31:26] == 6'd19 && insn[10:1] == 10'd560) kind = 4;
    else kind = 5;
    crbit = cr[31 - sel];                                                // R3
    cpass = bo[4] || (crbit == bo[3]);
    dec   = ctr_in - 64'd1;
    zero  = mode64 ? (dec == 64'd0) : (dec[31:0] == 32'd0);              // R5
    npass = bo[2] ? 1'b1 : (bo[1] ? zero : !zero);                       // R4
    legal = (kind != 5) && !(kind == 3 && bo[2] == 1'b0);                // R9
    seq   = cia + 64'd4;
    if (kind == 0) begin
      tk  = 1'b1;
      off = {{38{insn[25]}}, insn[25:2], 2'b00};
    end else begin
      tk  = (kind == 3) ? cpass : (cpass && npass);
      off = {{48{insn[15]}}, insn[15:2], 2'b00};
    end
    case (kind)
      0, 1: tgt = insn[1] ? off : cia + off;                             // R7
      2: tgt = lr_in & ~64'd3;                                           // R8
      3: tgt = ctr_in & ~64'd3;
      default: tgt = tar_in & ~64'd3;
    endcase
    if (!tk) tgt = seq;                                                  // R6
    if (!mode64) begin                                                   // R12
      tgt = tgt & 64'h0000_0000_FFFF_FFFF;
      seq = seq & 64'h0000_0000_FFFF_FFFF;
    end
    e_ill   = !legal;
    e_nia   = legal ? tgt : cia;                                         // R10
    e_lrwe  = legal && insn[0];                                          // R11
    e_lrd   = seq;
    e_ctrwe = legal && (kind == 1 || kind == 2 || kind == 4) && !bo[2];
    e_ctrd  = dec;
  endtask

  task automatic run(input string tag);
    predict();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1 out_valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " R10 illegal"}, {63'd0, illegal}, {63'd0, e_ill});
    chk({tag, " R6 nia"}, nia, e_nia);
    chk({tag, " R11 lr_we"}, {63'd0, lr_we}, {63'd0, e_lrwe});
    if (e_lrwe) chk({tag, " R11 lr_wdata"}, lr_wdata, e_lrd);
    chk({tag, " R4 ctr_we"}, {63'd0, ctr_we}, {63'd0, e_ctrwe});
    if (e_ctrwe) chk({tag, " R4 ctr_wdata"}, ctr_wdata, e_ctrd);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] ctrs [4];
    ctrs[0] = 64'd1;
    ctrs[1] = 64'd2;
    ctrs[2] = 64'h0000_0001_0000_0001;
    ctrs[3] = 64'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset lr_we", {63'd0, lr_we}, 64'd0);
    chk("R1 reset ctr_we", {63'd0, ctr_we}, 64'd0);
    chk("R1 reset illegal", {63'd0, illegal}, 64'd0);
    chk("R1 reset nia", nia, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    cia    = 64'h0000_0012_3456_7800;
    lr_in  = 64'hABCD_0000_0000_4003;
    tar_in = 64'h0000_7777_8888_9992;

    // R3 R4 R5 R8 R9 sweep over every option encoding and form
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 4; f++)
        for (int bo = 0; bo < 32; bo++)
          for (int cv = 0; cv < 2; cv++)
            for (int cs = 0; cs < 4; cs++)
              for (int lk = 0; lk < 2; lk++) begin
                logic [4:0] bi;
                bi = 5'((bo * 7 + cs * 3 + f) % 32);
                mode64 = m[0];
                cr = cv[0] ? (32'h8000_0000 >> bi) : ~(32'h8000_0000 >> bi);
                ctr_in = ctrs[cs];
                case (f)
                  0: insn = mk_bc(5'(bo), bi, cs[0] ? 14'h3FF0 : 14'h0040, cs[1], lk[0]);
                  1: insn = mk_ind(5'(bo), bi, 10'd16, lk[0]);
                  2: insn = mk_ind(5'(bo), bi, 10'd528, lk[0]);
                  default: insn = mk_ind(5'(bo), bi, 10'd560, lk[0]);
                endcase
                run("sweep R3 R5 R9");
              end

    // R7 R12 unconditional branches
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 8; k++) begin
        mode64 = m[0];
        insn = mk_b((k % 2 == 0) ? 24'h00_1234 : 24'hFF_FF00, k[1], k[2]);
        run("uncond R7 R12");
      end

    // R2 R10 bad opcodes and extended codes
    mode64 = 1'b1;
    insn = {6'd17, 26'h3FF_FFFF}; run("bad op R2");
    insn = {6'd0, 26'h0000001};   run("bad op R2");
    insn = mk_ind(5'b10100, 5'd0, 10'd17, 1'b1); run("bad xo R2");
    insn = mk_ind(5'b10100, 5'd0, 10'd529, 1'b0); run("bad xo R2");

    // R1 idle cycle after a result
    @(negedge clk);
    chk("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 idle lr_we", {63'd0, lr_we}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule